// File: doc/BRIEF.md
# Dual-Channel High/Low-Count Pulse Generator

This block drives two independent pulse-width-modulated pins from a single clock. Each channel is described by two 16-bit counts. The first is how many prescaled ticks the pin stays high. The second is how many it then stays low. The period is therefore the sum of the two counts, and no compare value is involved.

Every channel takes its tick from one of four single-cycle strobe inputs. These strobes stand in for candidate clock sources, so the block needs no clock multiplexing. The chosen strobe is divided by N+1, with N a 7-bit value. Enables, source selects and dividers for both channels live in one shared control word.

Software programs the block through a word-addressed register port with a write strobe. Read data is combinational on the address.

Top module: `pwm_pair`

## Requirements
- R1: Byte offset 0x0 is channel A's duty word, 0x4 is channel B's duty word and 0x8 is the control word; only address bits [3:2] are decoded. Each word reads back exactly what was last written. Offset 0xC reads as zero, and a write to it changes no register.
- R2: In a duty word, bits [31:16] are the high-phase count and bits [15:0] are the low-phase count, both in prescaled ticks.
- R3: Control word fields:
  - Output enables: bit 0 is channel A and bit 1 is channel B.
  - Source selects: [5:4] for A and [7:6] for B; value k picks strobe input src_tick[k].
  - Dividers: [14:8] for A and [22:16] for B.
  - Prescaler run bits: bit 15 for A and bit 23 for B.
- R4: With divider value N, a channel produces one tick per N+1 asserted cycles of its selected strobe.
- R5: After enable, a channel's pin is high for exactly the high count of ticks, then low for exactly the low count, and repeats. The pin changes in the clock edge that consumes the tick.
- R6: A high count of 0 keeps the pin low. A low count of 0 keeps it high. Both counts at 0 keep it low.
- R7: A duty word written while its channel runs takes effect only at the end of the current full period.
- R8: While a channel's enable is clear, its pin is low and its prescaler and phase position are cleared. Setting the enable again starts a fresh high phase with the current duty word.
- R9: While a channel's prescaler run bit is clear, its prescaler and phase position hold their values.
- R10: After reset, all registers read zero and both pins are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Byte address of the register word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| src_tick | input | 4 | Four candidate tick strobes |
| pwm_out | output | 2 | Pins: bit 0 channel A, bit 1 channel B |

## Verification
Latencies are as follows:
- A register write is visible on reg_rdata one edge after the strobe.
- A change of enable or working counts reaches pwm_out at that same edge.
- A strobe that completes a prescaler count moves the pin at the edge where it is sampled.

The bench keeps a behavioural model that advances on the same clock edge, applying the same latencies. It drives all inputs one nanosecond after the rising edge and compares pwm_out and reg_rdata against the model at every falling edge. A mismatch is therefore pinned to the exact cycle in which it appears.

// File: rtl/pwm_pair_pkg.sv
package pwm_pair_pkg;
  localparam int NCH      = 2;
  localparam int DATA_W   = 32;
  localparam int CNT_W    = 16;
  localparam int DIV_W    = 7;
  localparam int NSRC     = 4;
  localparam int SEL_W    = $clog2(NSRC);
  // word index decoded from reg_addr[3:2]
  localparam logic [1:0] WIDX_DUTY_A = 2'd0;
  localparam logic [1:0] WIDX_DUTY_B = 2'd1;
  localparam logic [1:0] WIDX_CTRL   = 2'd2;
  // control field positions per channel
  localparam int EN_POS0   = 0;
  localparam int SEL_POS0  = 4;
  localparam int DIV_POS0  = 8;
  localparam int RUN_POS0  = 15;
  localparam int CH_STRIDE = 8;
endpackage

// File: rtl/pwm_pair_regs.sv
module pwm_pair_regs
  import pwm_pair_pkg::*;
(
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr,
  input  logic [3:0]                     addr,
  input  logic [DATA_W-1:0]              wdata,
  output logic [DATA_W-1:0]              rdata,
  output logic [NCH-1:0][DATA_W-1:0]     duty,
  output logic [DATA_W-1:0]              ctrl
);
  logic [1:0] widx;
  assign widx = addr[3:2];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      duty <= '0;
      ctrl <= '0;
    end else if (wr) begin
      case (widx)
        WIDX_DUTY_A: duty[0] <= wdata;
        WIDX_DUTY_B: duty[1] <= wdata;
        WIDX_CTRL:   ctrl    <= wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (widx)
      WIDX_DUTY_A: rdata = duty[0];
      WIDX_DUTY_B: rdata = duty[1];
      WIDX_CTRL:   rdata = ctrl;
      default:     rdata = '0;
    endcase
  end

  assert_unmapped_ignored_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && widx == 2'd3) |=> ($stable(ctrl) && $stable(duty)));
endmodule

// File: rtl/pwm_pair_prescale.sv
module pwm_pair_prescale
  import pwm_pair_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             run,
  input  logic [SEL_W-1:0] sel,
  input  logic [DIV_W-1:0] div,
  input  logic [NSRC-1:0]  src,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;
  logic             strobe;

  assign strobe = src[sel];
  assign tick   = en && run && strobe && (cnt == div);

  always_ff @(posedge clk) begin
    if (!rst_n || !en) cnt <= '0;
    else if (run && strobe) begin
      if (cnt == div) cnt <= '0;
      else            cnt <= cnt + 1'b1;
    end
  end

  assert_cleared_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (cnt == '0));
  assert_hold_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !run) |=> $stable(cnt));
endmodule

// File: rtl/pwm_pair_phase.sv
module pwm_pair_phase
  import pwm_pair_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             tick,
  input  logic [CNT_W-1:0] hi_in,
  input  logic [CNT_W-1:0] lo_in,
  output logic             out
);
  localparam int POS_W = CNT_W + 1;

  logic [CNT_W-1:0] hi_w, lo_w;
  logic [POS_W-1:0] pos, total;
  logic             last;

  assign total = {1'b0, hi_w} + {1'b0, lo_w};
  assign last  = (pos + 1'b1) >= total;
  assign out   = en && (pos < {1'b0, hi_w});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos  <= '0;
      hi_w <= '0;
      lo_w <= '0;
    end else if (!en) begin
      pos  <= '0;
      hi_w <= hi_in;
      lo_w <= lo_in;
    end else if (tick) begin
      if (last) begin
        pos  <= '0;
        hi_w <= hi_in;
        lo_w <= lo_in;
      end else begin
        pos <= pos + 1'b1;
      end
    end
  end

  assert_pos_cleared_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (pos == '0));
  assert_pos_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !tick) |=> ($stable(pos) && $stable(hi_w) && $stable(lo_w)));
  assert_pos_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (total != '0) |-> (pos < total));
endmodule

// File: rtl/pwm_pair.sv
module pwm_pair
  import pwm_pair_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [3:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [3:0]        src_tick,
  output logic [1:0]        pwm_out
);
  logic [NCH-1:0][DATA_W-1:0] duty;
  logic [DATA_W-1:0]          ctrl;

  pwm_pair_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .duty(duty), .ctrl(ctrl)
  );

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    logic tick;

    pwm_pair_prescale u_pre (
      .clk(clk), .rst_n(rst_n),
      .en(ctrl[EN_POS0 + ch]),
      .run(ctrl[RUN_POS0 + ch*CH_STRIDE]),
      .sel(ctrl[SEL_POS0 + ch*SEL_W +: SEL_W]),
      .div(ctrl[DIV_POS0 + ch*CH_STRIDE +: DIV_W]),
      .src(src_tick),
      .tick(tick)
    );

    pwm_pair_phase u_phase (
      .clk(clk), .rst_n(rst_n),
      .en(ctrl[EN_POS0 + ch]),
      .tick(tick),
      .hi_in(duty[ch][DATA_W-1 -: CNT_W]),
      .lo_in(duty[ch][CNT_W-1:0]),
      .out(pwm_out[ch])
    );
  end
endmodule

// File: tb/pwm_pair_bench.sv
`timescale 1ns/1ps
module pwm_pair_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [3:0]  reg_addr = 4'h0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [3:0]  src_tick = '0;
  logic [1:0]  pwm_out;

  int checks = 0;
  int errors = 0;
  string cur_req = "R10";
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pwm_pair u_pwm_pair (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .src_tick(src_tick),
    .pwm_out(pwm_out)
  );

  // ---------------- behavioural reference ----------------
  logic [31:0] m_reg [0:2];
  int m_pc [0:1];
  int m_pos [0:1];
  int m_hi [0:1];
  int m_lo [0:1];

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 3; i++) m_reg[i] = '0;
      for (int c = 0; c < 2; c++) begin
        m_pc[c] = 0; m_pos[c] = 0; m_hi[c] = 0; m_lo[c] = 0;
      end
    end else begin
      for (int c = 0; c < 2; c++) begin
        bit en, run, tk;
        int sel, dv;
        en  = m_reg[2][c];
        run = m_reg[2][15 + 8*c];
        sel = (m_reg[2] >> (4 + 2*c)) & 3;
        dv  = (m_reg[2] >> (8 + 8*c)) & 127;
        tk  = 1'b0;
        if (!en) m_pc[c] = 0;
        else if (run && src_tick[sel]) begin
          if (m_pc[c] == dv) begin tk = 1'b1; m_pc[c] = 0; end
          else m_pc[c]++;
        end
        if (!en || (tk && m_pos[c] + 1 >= m_hi[c] + m_lo[c])) begin
          m_pos[c] = 0;
          m_hi[c] = m_reg[c][31:16];
          m_lo[c] = m_reg[c][15:0];
        end else if (tk) m_pos[c]++;
      end
      if (reg_wr && reg_addr[3:2] != 2'd3) m_reg[reg_addr[3:2]] = reg_wdata;
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison
  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [1:0] e_out;
      logic [31:0] e_rd;
      for (int c = 0; c < 2; c++)
        e_out[c] = m_reg[2][c] && (m_pos[c] < m_hi[c]);
      e_rd = (reg_addr[3:2] == 2'd3) ? 32'h0 : m_reg[reg_addr[3:2]];
      check(cur_req, {30'h0, pwm_out}, {30'h0, e_out});
      check({cur_req, "/R1"}, reg_rdata, e_rd);
    end
  end

  // strobe sources
  int cyc = 0;
  logic [7:0] lfsr = 8'hA5;
  always @(posedge clk) begin
    #1;
    cyc++;
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    src_tick[0] = 1'b1;
    src_tick[1] = cyc[0];
    src_tick[2] = (cyc % 3 == 0);
    src_tick[3] = lfsr[0];
  end

  function automatic logic [31:0] chf(int c, bit en, bit run, int sel, int dv);
    logic [31:0] w = '0;
    w[c] = en;
    w[15 + 8*c] = run;
    w[4 + 2*c +: 2] = sel[1:0];
    w[8 + 8*c +: 7] = dv[6:0];
    return w;
  endfunction

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(posedge clk); #1;
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, logic [31:0] exp, string req);
    @(posedge clk); #1;
    reg_addr = a;
    @(negedge clk);
    check(req, reg_rdata, exp);
  endtask

  task automatic idle(int n);
    repeat (n) @(posedge clk);
  endtask

  initial begin
    #150000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    idle(4);
    @(posedge clk); #1 rst_n = 1'b1;
    // R10: reset state
    cur_req = "R10";
    rd(4'h0, 32'h0, "R10");
    rd(4'h4, 32'h0, "R10");
    rd(4'h8, 32'h0, "R10");
    check("R10", {30'h0, pwm_out}, 32'h0);
    // R1/R2: map and readback, unmapped ignored
    cur_req = "R1";
    wr(4'h0, 32'h0003_0005);
    wr(4'h4, 32'h0002_0001);
    wr(4'hC, 32'hFFFF_FFFF);
    rd(4'h0, 32'h0003_0005, "R2");
    rd(4'h4, 32'h0002_0001, "R2");
    rd(4'hC, 32'h0, "R1");
    rd(4'h8, 32'h0, "R1");
    rd(4'h3, 32'h0003_0005, "R1");
    // R3/R5: channel A, every-cycle ticks
    cur_req = "R5";
    wr(4'h8, chf(0, 1, 1, 0, 0));
    rd(4'h8, 32'h0000_8001, "R3");
    idle(30);
    // R4: divide by 3 of strobe 1
    cur_req = "R4";
    wr(4'h8, chf(0, 0, 1, 1, 2));
    wr(4'h8, chf(0, 1, 1, 1, 2));
    idle(70);
    // R7: duty change mid-period
    cur_req = "R7";
    wr(4'h0, 32'h0001_0002);
    idle(40);
    // channel B with random strobe in parallel
    cur_req = "R3";
    wr(4'h8, chf(0, 1, 1, 1, 2) | chf(1, 1, 1, 3, 1));
    idle(60);
    // R6: degenerate counts
    cur_req = "R6";
    wr(4'h0, 32'h0000_0004);
    idle(30);
    wr(4'h0, 32'h0004_0000);
    idle(30);
    wr(4'h0, 32'h0000_0000);
    idle(30);
    // R9: prescaler halted
    cur_req = "R9";
    wr(4'h0, 32'h0005_0003);
    wr(4'h8, chf(0, 1, 1, 0, 0) | chf(1, 1, 1, 3, 1));
    idle(10);
    wr(4'h8, chf(0, 1, 0, 0, 0) | chf(1, 1, 0, 3, 1));
    idle(20);
    wr(4'h8, chf(0, 1, 1, 0, 0) | chf(1, 1, 1, 3, 1));
    idle(20);
    // R8: disable and re-enable
    cur_req = "R8";
    wr(4'h8, chf(0, 0, 1, 0, 0) | chf(1, 1, 1, 3, 1));
    @(negedge clk);
    check("R8", {31'h0, pwm_out[0]}, 32'h0);
    idle(10);
    wr(4'h8, chf(0, 1, 1, 0, 0) | chf(1, 1, 1, 3, 1));
    idle(40);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule